// File: doc/BRIEF.md
# Parallel display write strobe sequencer

This block turns single write requests into strobe sequences on an asynchronous parallel write bus that feeds a display controller. Each request comes in over a valid/ready handshake and carries a data word and a flag that marks the word as a command or as display data. The block drives the register-select line and the data bus first. It then lowers chip select, then pulses write enable, and finally releases chip select after a hold time.

Four 4-bit timing inputs set the length of each phase, counted in cycles of the block clock. A field value N always gives N+1 cycles, so a field of zero still yields a one-cycle phase. The block copies the timing inputs when it accepts a request, so software may change them at any time. Two more configuration bits invert the data-enable output and the latch-clock output.

Top module: `pbus_wr_timer`

## Requirements
- R1: After reset, chip select (`bus_cs_n`) and write enable (`bus_we_n`) are high, and `req_ready` is high.
- R2: After acceptance (`req_valid` and `req_ready` high at a clock edge), the register-select line and the data bus are valid from the next cycle. Chip select stays high for `cfg_addr_setup`+1 cycles, counted from that cycle, and then goes low.
- R3: After chip select goes low, write enable stays high for `cfg_sel_setup`+1 cycles and then goes low.
- R4: Write enable stays low for `cfg_strobe_width`+1 cycles, and only while chip select is low.
- R5: After write enable rises, chip select stays low for `cfg_hold`+1 cycles and then rises.
- R6: From the cycle after acceptance through the last hold cycle, `bus_data` equals the accepted `req_data`. `bus_rs` is 0 for a command (`req_is_cmd`=1) and 1 for data.
- R7: `req_ready` is low from the cycle after acceptance until the cycle in which chip select rises, and it is high in that cycle. A request held valid there starts its address phase in the next cycle.
- R8: The timing fields are sampled only at acceptance. A change during a transfer does not alter that transfer's phase lengths.
- R9: `bus_den` equals 1 XOR `cfg_inv_en` while write enable is low and during the hold phase. At all other times it equals `cfg_inv_en`.
- R10: `bus_lclk` equals 1 XOR `cfg_inv_clk` while write enable is low. At all other times it equals `cfg_inv_clk`.
- R11: When idle, `bus_cs_n` and `bus_we_n` stay high, and `bus_data` and `bus_rs` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; every phase is counted in its cycles |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr_setup | input | 4 | Address-to-select setup, N+1 cycles |
| cfg_sel_setup | input | 4 | Select-to-strobe setup, N+1 cycles |
| cfg_strobe_width | input | 4 | Write strobe low width, N+1 cycles |
| cfg_hold | input | 4 | Strobe-release-to-select-release hold, N+1 cycles |
| cfg_inv_en | input | 1 | Invert `bus_den` |
| cfg_inv_clk | input | 1 | Invert `bus_lclk` |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block can accept a request |
| req_is_cmd | input | 1 | 1 = command word, 0 = display data |
| req_data | input | 16 | Word to write |
| bus_rs | output | 1 | Register select, 0 for a command |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_data | output | 16 | Data bus |
| bus_den | output | 1 | Data-enable window, polarity set by `cfg_inv_en` |
| bus_lclk | output | 1 | Latch clock, polarity set by `cfg_inv_clk` |

## Verification
The assertions assume that both polarity bits stay constant during a transfer. They also assume that `req_data` and `req_is_cmd` are sampled only at acceptance, so their values at other times do not matter. The bench changes the polarity bits only between transfers, while the block is idle. It changes the four timing fields in the middle of every transfer, which checks that they are sampled only at acceptance.

// File: rtl/pbw_pkg.sv
package pbw_pkg;
    localparam int TW = 4;

    typedef enum logic [2:0] {
        PH_IDLE, PH_ADDR, PH_SEL, PH_ACT, PH_HOLD
    } phase_e;

    typedef struct packed {
        logic [TW-1:0] addr_setup;
        logic [TW-1:0] sel_setup;
        logic [TW-1:0] strobe;
        logic [TW-1:0] hold;
    } timing_t;

    localparam timing_t TIMING_RESET = '{addr_setup: '0, sel_setup: '0,
                                         strobe: TW'(1), hold: '0};

    function automatic logic [TW-1:0] count_down(input logic [TW-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction
endpackage

// File: rtl/pbw_phase_ctrl.sv
module pbw_phase_ctrl
    import pbw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  timing_t start_tim,
    output logic    idle,
    output logic    cs_n,
    output logic    we_n,
    output logic    den_act,
    output logic    strobe_act
);
    phase_e        phase;
    timing_t       tim;
    logic [TW-1:0] cnt;
    logic          last;

    assign last = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            tim   <= TIMING_RESET;
            cnt   <= '0;
            cs_n  <= 1'b1;
            we_n  <= 1'b1;
        end else begin
            case (phase)
                PH_IDLE: if (start) begin
                    tim   <= start_tim;
                    cnt   <= start_tim.addr_setup;
                    phase <= PH_ADDR;
                end
                PH_ADDR: if (last) begin
                    cnt   <= tim.sel_setup;
                    cs_n  <= 1'b0;
                    phase <= PH_SEL;
                end else cnt <= count_down(cnt);
                PH_SEL: if (last) begin
                    cnt   <= tim.strobe;
                    we_n  <= 1'b0;
                    phase <= PH_ACT;
                end else cnt <= count_down(cnt);
                PH_ACT: if (last) begin
                    cnt   <= tim.hold;
                    we_n  <= 1'b1;
                    phase <= PH_HOLD;
                end else cnt <= count_down(cnt);
                PH_HOLD: if (last) begin
                    cs_n  <= 1'b1;
                    phase <= PH_IDLE;
                end else cnt <= count_down(cnt);
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign idle       = (phase == PH_IDLE);
    assign den_act    = (phase == PH_ACT) || (phase == PH_HOLD);
    assign strobe_act = (phase == PH_ACT);
endmodule

// File: rtl/pbw_out_stage.sv
module pbw_out_stage #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              is_cmd,
    input  logic [DATA_W-1:0] data_in,
    input  logic              den_act,
    input  logic              strobe_act,
    input  logic              inv_en,
    input  logic              inv_clk,
    output logic              rs,
    output logic [DATA_W-1:0] data_out,
    output logic              den,
    output logic              lclk
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rs       <= 1'b1;
            data_out <= '0;
        end else if (load) begin
            rs       <= ~is_cmd;
            data_out <= data_in;
        end
    end

    assign den  = den_act ^ inv_en;
    assign lclk = strobe_act ^ inv_clk;
endmodule

// File: rtl/pbus_wr_timer.sv
module pbus_wr_timer
    import pbw_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TW-1:0]     cfg_addr_setup,
    input  logic [TW-1:0]     cfg_sel_setup,
    input  logic [TW-1:0]     cfg_strobe_width,
    input  logic [TW-1:0]     cfg_hold,
    input  logic              cfg_inv_en,
    input  logic              cfg_inv_clk,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_is_cmd,
    input  logic [DATA_W-1:0] req_data,
    output logic              bus_rs,
    output logic              bus_cs_n,
    output logic              bus_we_n,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_den,
    output logic              bus_lclk
);
    logic    accept;
    logic    den_act;
    logic    strobe_act;
    timing_t req_tim;

    assign accept  = req_valid && req_ready;
    assign req_tim = '{addr_setup: cfg_addr_setup, sel_setup: cfg_sel_setup,
                       strobe: cfg_strobe_width, hold: cfg_hold};

    pbw_phase_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(accept), .start_tim(req_tim),
        .idle(req_ready), .cs_n(bus_cs_n), .we_n(bus_we_n),
        .den_act(den_act), .strobe_act(strobe_act)
    );

    pbw_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst(rst), .load(accept), .is_cmd(req_is_cmd),
        .data_in(req_data), .den_act(den_act), .strobe_act(strobe_act),
        .inv_en(cfg_inv_en), .inv_clk(cfg_inv_clk),
        .rs(bus_rs), .data_out(bus_data), .den(bus_den), .lclk(bus_lclk)
    );
endmodule

// File: rtl/pbus_wr_timer_chk.sv
module pbus_wr_timer_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_inv_en,
    input logic              cfg_inv_clk,
    input logic              req_valid,
    input logic              req_ready,
    input logic              bus_rs,
    input logic              bus_cs_n,
    input logic              bus_we_n,
    input logic [DATA_W-1:0] bus_data,
    input logic              bus_den,
    input logic              bus_lclk
);
    AST_WE_INSIDE_CS: assert property (@(posedge clk) disable iff (rst)
        !bus_we_n |-> !bus_cs_n); // R4
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        !bus_cs_n |-> !req_ready); // R7
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        (!bus_cs_n && $past(!bus_cs_n)) |-> ($stable(bus_data) && $stable(bus_rs))); // R6
    AST_WE_AFTER_CS: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_we_n) |-> $past(!bus_cs_n)); // R3
    AST_HOLD_NONZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_cs_n) |-> $past(bus_we_n)); // R5
    AST_DEN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (bus_den ^ cfg_inv_en) |-> !bus_cs_n); // R9
    AST_LCLK_STROBE: assert property (@(posedge clk) disable iff (rst)
        (bus_lclk ^ cfg_inv_clk) |-> !bus_we_n); // R10
    AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (rst)
        (bus_cs_n && $past(bus_cs_n) && !$past(req_valid && req_ready))
        |-> $stable(bus_data)); // R11
endmodule

bind pbus_wr_timer pbus_wr_timer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .cfg_inv_en(cfg_inv_en), .cfg_inv_clk(cfg_inv_clk),
    .req_valid(req_valid), .req_ready(req_ready), .bus_rs(bus_rs),
    .bus_cs_n(bus_cs_n), .bus_we_n(bus_we_n), .bus_data(bus_data),
    .bus_den(bus_den), .bus_lclk(bus_lclk)
);

// File: tb/pbus_wr_timer_test.sv
`timescale 1ns/1ps
module pbus_wr_timer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  ta = 0, tb_ = 0, tc = 1, td = 0;
    logic        inv_en = 0, inv_clk = 0;
    logic        valid = 0, is_cmd = 0;
    logic [15:0] data = 0;
    logic        ready, rs, cs_n, we_n, den, lclk;
    logic [15:0] bdata;
    int checks = 0, failures = 0;

    always #2 clk = ~clk;

    pbus_wr_timer uut (
        .clk(clk), .rst(rst), .cfg_addr_setup(ta), .cfg_sel_setup(tb_),
        .cfg_strobe_width(tc), .cfg_hold(td), .cfg_inv_en(inv_en),
        .cfg_inv_clk(inv_clk), .req_valid(valid), .req_ready(ready),
        .req_is_cmd(is_cmd), .req_data(data), .bus_rs(rs), .bus_cs_n(cs_n),
        .bus_we_n(we_n), .bus_data(bdata), .bus_den(den), .bus_lclk(lclk)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Starts at a negedge with the block idle; ends at the negedge where cs_n rises.
    task automatic do_write(input logic [3:0] a, b, c, d, input logic cmd,
                            input logic [15:0] w);
        int n_addr = 0, n_sel = 0, n_act = 0, n_hold = 0;
        int bad_data = 0, bad_ready = 0, bad_den = 0, bad_lclk = 0;
        chk("R7 ready before request", int'(ready), 1);
        ta = a; tb_ = b; tc = c; td = d; is_cmd = cmd; data = w; valid = 1;
        @(negedge clk);
        valid = 0;
        ta = ~a; tb_ = ~b; tc = ~c; td = ~d; data = ~w; is_cmd = ~cmd; // R8
        for (int i = 0; i < 40 && cs_n; i++) begin
            n_addr++;
            if (bdata !== w || rs !== ~cmd) bad_data++;
            if (ready) bad_ready++;
            if (den !== inv_en) bad_den++;
            @(negedge clk);
        end
        for (int i = 0; i < 40 && !cs_n && we_n; i++) begin
            n_sel++;
            if (bdata !== w || rs !== ~cmd) bad_data++;
            if (ready) bad_ready++;
            if (den !== inv_en || lclk !== inv_clk) bad_den++;
            @(negedge clk);
        end
        for (int i = 0; i < 40 && !we_n; i++) begin
            n_act++;
            if (bdata !== w || rs !== ~cmd || cs_n) bad_data++;
            if (ready) bad_ready++;
            if (den !== ~inv_en) bad_den++;
            if (lclk !== ~inv_clk) bad_lclk++;
            @(negedge clk);
        end
        for (int i = 0; i < 40 && !cs_n; i++) begin
            n_hold++;
            if (bdata !== w || rs !== ~cmd) bad_data++;
            if (ready) bad_ready++;
            if (den !== ~inv_en) bad_den++;
            if (lclk !== inv_clk) bad_lclk++;
            @(negedge clk);
        end
        chk("R2 address phase length", n_addr, int'(a) + 1);
        chk("R3 select setup length", n_sel, int'(b) + 1);
        chk("R4 strobe width", n_act, int'(c) + 1);
        chk("R5 hold length", n_hold, int'(d) + 1);
        chk("R6 data/rs mismatches", bad_data, 0);
        chk("R7 ready high while busy", bad_ready, 0);
        chk("R7 ready at release", int'(ready), 1);
        chk("R9 den mismatches", bad_den, 0);
        chk("R9 den after release", int'(den), int'(inv_en));
        chk("R10 lclk mismatches", bad_lclk, 0);
    endtask

    task automatic t_reset;
        chk("R1 cs_n after reset", int'(cs_n), 1);
        chk("R1 we_n after reset", int'(we_n), 1);
        chk("R1 ready after reset", int'(ready), 1);
    endtask

    task automatic t_idle_keep(input logic [15:0] w, input logic r);
        int bad = 0;
        data = 16'h5A5A; is_cmd = ~r;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (!cs_n || !we_n || bdata !== w || rs !== r) bad++;
        end
        chk("R11 idle outputs changed", bad, 0);
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        do_write(4'd0, 4'd0, 4'd1, 4'd0, 1'b1, 16'h0011);
        t_idle_keep(16'h0011, 1'b0);
        do_write(4'd3, 4'd2, 4'd5, 4'd4, 1'b0, 16'hBEEF);
        // back-to-back: next request at the release cycle (R7)
        do_write(4'd0, 4'd0, 4'd0, 4'd0, 1'b1, 16'h1234);
        do_write(4'd15, 4'd15, 4'd15, 4'd15, 1'b0, 16'hFFFF);
        @(negedge clk);
        inv_en = 1; inv_clk = 1;
        @(negedge clk);
        chk("R9 inverted idle den", int'(den), 1);
        chk("R10 inverted idle lclk", int'(lclk), 1);
        do_write(4'd1, 4'd7, 4'd2, 4'd9, 1'b0, 16'hA55A);
        t_idle_keep(16'hA55A, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule